// File: doc/BRIEF.md
# AXI Page-Boundary Burst Splitter

This block sits between a DMA channel engine and an AXI address channel (read or write; one instance per channel). The engine hands it one logical burst: start address, beat count, beat size and burst type. If an incrementing burst would run past a 4 KB address boundary, the splitter emits two address-channel bursts. The first runs up to the boundary. The second starts at the next 4 KB-aligned address. Their beat counts add up to the requested count. The engine completes a single request handshake and never sees the split.

Fixed-address bursts touch one location on every beat, so they always go out as a single burst, unchanged. Wrapping bursts and the reserved burst code are refused: the request is consumed, nothing is emitted, and a one-cycle reject pulse reports it. The requester must keep each request's span (beats × bytes per beat) at or below 4096 bytes. Under that rule one split is always enough.

Top module: `axi_page_splitter`

## Requirements
- R1: An incrementing request (burst code 01) whose last byte lies beyond the 4 KB page of its start address is emitted as exactly two bursts, and the beat counts (ax_len+1) of the two bursts add up to the requested beat count (req_len+1).
- R2: When a request is split, the first burst keeps the request address and carries ceil((4096 − addr[11:0]) / 2^req_size) beats. The second burst starts at the next 4 KB-aligned address, with address bits [11:0] equal to zero.
- R3: Only burst codes 00 (fixed) and 01 (incrementing) ever appear on ax_burst, and each emitted burst carries the request's burst code.
- R4: A request with burst code 10 (wrapping) or 11 (reserved) is accepted and produces no burst. req_reject is high for exactly the one cycle after the acceptance edge.
- R5: A fixed request (code 00) is emitted as one burst with the request's address, length and size, even when address plus span would pass a boundary.
- R6: An incrementing request whose span stays within its page, including one ending exactly on a 4 KB boundary, is emitted as one burst identical to the request.
- R7: ax_len encodes beats − 1, and ax_size equals req_size on every emitted burst, including both halves of a split.
- R8: req_ready is high only while no burst is being presented. It returns high in the cycle after the final burst of a request is accepted.
- R9: The first burst is presented (ax_valid high) in the cycle after the request handshake. The second burst of a split is presented in the cycle after the first is accepted, and ax_valid stays high until the last burst is accepted.
- R10: While ax_valid is high and ax_ready is low, ax_addr, ax_len, ax_size and ax_burst hold their values.
- R11: During and right after reset, ax_valid and req_reject are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered by the channel engine |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_addr | input | 32 | Start byte address of the logical burst |
| req_len | input | 8 | Requested beats minus one |
| req_size | input | 3 | Bytes per beat as a power of two |
| req_burst | input | 2 | Burst code: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| req_reject | output | 1 | One-cycle pulse after a refused request |
| ax_valid | output | 1 | Address-channel burst valid |
| ax_ready | input | 1 | Address-channel burst accepted |
| ax_addr | output | 32 | Burst start address |
| ax_len | output | 8 | Burst beats minus one |
| ax_size | output | 3 | Burst beat size, copied from the request |
| ax_burst | output | 2 | Burst code, 00 or 01 only |

## Verification
Every result has a fixed delay counted from a clock edge. The first burst or the reject pulse appears one cycle after the request edge. The second burst appears one cycle after the edge that accepts the first. req_ready rises one cycle after the edge that accepts the last burst. The bench drives inputs and samples outputs on the falling edge. After each request edge it samples at the very next falling edge, so these one-cycle delays are checked exactly. While bursts are outstanding it varies ax_ready at random. It compares a burst against its expected value only in the half cycle in which ax_ready is high. In stalled cycles it checks that the presented fields have not changed.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
        burst_e            burst;
    } burst_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HEAD = 2'b01,
        ST_LAST = 2'b10
    } split_state_e;

    function automatic logic burst_is_legal(burst_e b);
        return (b == BT_FIXED) || (b == BT_INCR);
    endfunction

endpackage

// File: rtl/bsplit_calc.sv
module bsplit_calc
    import bsplit_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  burst_desc_t req,
    output burst_desc_t head,
    output burst_desc_t tail,
    output logic        split,
    output logic        legal
);
    localparam int CNT_W = ((LEN_W > PAGE_W) ? LEN_W : PAGE_W) + 3;
    localparam int HI_W  = ADDR_W - PAGE_W;

    logic [CNT_W-1:0] room_bytes;
    logic [CNT_W-1:0] bytes_m1;
    logic [CNT_W-1:0] room_beats;
    logic [CNT_W-1:0] req_beats;
    logic [HI_W-1:0]  next_page;

    always_comb begin
        room_bytes = (CNT_W'(1) << PAGE_W) - CNT_W'(req.addr[PAGE_W-1:0]);
        bytes_m1   = (CNT_W'(1) << req.size) - CNT_W'(1);
        room_beats = (room_bytes + bytes_m1) >> req.size;
        req_beats  = CNT_W'(req.len) + CNT_W'(1);
        next_page  = req.addr[ADDR_W-1:PAGE_W] + HI_W'(1);
        legal      = burst_is_legal(req.burst);
        split      = (req.burst == BT_INCR) && (req_beats > room_beats);
        head       = req;
        tail       = req;
        if (split) begin
            head.len  = LEN_W'(room_beats - CNT_W'(1));
            tail.len  = LEN_W'(req_beats - room_beats - CNT_W'(1));
            tail.addr = {next_page, {PAGE_W{1'b0}}};
        end
    end
endmodule

// File: rtl/bsplit_ctrl.sv
module bsplit_ctrl
    import bsplit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_fire,
    input  logic        legal,
    input  logic        split,
    input  burst_desc_t head,
    input  burst_desc_t tail,
    input  logic        ax_ready,
    output logic        idle,
    output logic        out_valid,
    output burst_desc_t out_desc,
    output logic        reject
);
    split_state_e state_q;
    burst_desc_t  out_q;
    burst_desc_t  tail_q;
    logic         rej_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            out_q   <= '0;
            tail_q  <= '0;
            rej_q   <= 1'b0;
        end else begin
            rej_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_fire) begin
                        if (!legal) begin
                            rej_q <= 1'b1;
                        end else begin
                            out_q   <= head;
                            tail_q  <= tail;
                            state_q <= split ? ST_HEAD : ST_LAST;
                        end
                    end
                end
                ST_HEAD: begin
                    if (ax_ready) begin
                        out_q   <= tail_q;
                        state_q <= ST_LAST;
                    end
                end
                ST_LAST: begin
                    if (ax_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign out_valid = (state_q != ST_IDLE);
    assign out_desc  = out_q;
    assign reject    = rej_q;
endmodule

// File: rtl/axi_page_splitter.sv
module axi_page_splitter
    import bsplit_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_burst,
    output logic              req_reject,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [LEN_W-1:0]  ax_len,
    output logic [SIZE_W-1:0] ax_size,
    output logic [1:0]        ax_burst
);
    burst_desc_t req_d;
    burst_desc_t head_d;
    burst_desc_t tail_d;
    burst_desc_t out_d;
    logic        split_d;
    logic        legal_d;
    logic        idle_d;

    always_comb begin
        req_d.addr  = req_addr;
        req_d.len   = req_len;
        req_d.size  = req_size;
        req_d.burst = burst_e'(req_burst);
    end

    bsplit_calc #(.PAGE_W(PAGE_W)) u_calc (
        .req   (req_d),
        .head  (head_d),
        .tail  (tail_d),
        .split (split_d),
        .legal (legal_d)
    );

    bsplit_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_valid && idle_d),
        .legal     (legal_d),
        .split     (split_d),
        .head      (head_d),
        .tail      (tail_d),
        .ax_ready  (ax_ready),
        .idle      (idle_d),
        .out_valid (ax_valid),
        .out_desc  (out_d),
        .reject    (req_reject)
    );

    assign req_ready = idle_d;
    assign ax_addr   = out_d.addr;
    assign ax_len    = out_d.len;
    assign ax_size   = out_d.size;
    assign ax_burst  = out_d.burst;
endmodule

// File: rtl/axi_page_splitter_chk.sv
module axi_page_splitter_chk
    import bsplit_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic [SIZE_W-1:0] req_size,
    input logic [1:0]        req_burst,
    input logic              req_reject,
    input logic              ax_valid,
    input logic              ax_ready,
    input logic [ADDR_W-1:0] ax_addr,
    input logic [LEN_W-1:0]  ax_len,
    input logic [SIZE_W-1:0] ax_size,
    input logic [1:0]        ax_burst
);
    int span_end;

    always_comb begin
        span_end = (int'(ax_addr[PAGE_W-1:0]) & ~((1 << ax_size) - 1))
                 + ((int'(ax_len) + 1) << ax_size);
    end

    assert_only_fixed_incr_R3: assert property (@(posedge clk) disable iff (rst)
        ax_valid |-> (ax_burst == 2'b00 || ax_burst == 2'b01));

    assert_no_page_cross_R1: assert property (@(posedge clk) disable iff (rst)
        (ax_valid && ax_burst == 2'b01) |-> (span_end <= (1 << PAGE_W)));

    assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (rst)
        (ax_valid && !ax_ready) |=> (ax_valid && $stable(ax_addr) && $stable(ax_len)
                                     && $stable(ax_size) && $stable(ax_burst)));

    assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !ax_valid);

    assert_second_page_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (ax_valid && $past(ax_valid && ax_ready)) |->
            (ax_addr[PAGE_W-1:0] == '0 && ax_burst == 2'b01));

    assert_reject_follows_refusal_R4: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> $past(req_valid && req_ready && req_burst[1]));

    assert_reject_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> !ax_valid);
endmodule

bind axi_page_splitter axi_page_splitter_chk #(.PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/sim_axi_page_splitter.sv
module sim_axi_page_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic        req_reject;
    logic        ax_valid;
    logic        ax_ready = 1'b0;
    logic [31:0] ax_addr;
    logic [7:0]  ax_len;
    logic [2:0]  ax_size;
    logic [1:0]  ax_burst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_page_splitter u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .req_burst(req_burst), .req_reject(req_reject), .ax_valid(ax_valid),
        .ax_ready(ax_ready), .ax_addr(ax_addr), .ax_len(ax_len),
        .ax_size(ax_size), .ax_burst(ax_burst)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] addr, input int beats,
                           input int size, input int burst);
        int          exp_n;
        logic [31:0] ea [2];
        int          eb [2];
        int          bytes;
        int          room;
        int          k;
        int          got_sum;
        string       tag;
        bit          stalled;
        logic [31:0] s_addr;
        logic [7:0]  s_len;
        bytes = 1 << size;
        room  = (PAGE - int'(addr[11:0]) + bytes - 1) / bytes;
        if (burst >= 2) begin
            exp_n = 0;
            tag = "R4";
        end else if (burst == 1 && beats > room) begin
            exp_n = 2;
            ea[0] = addr; eb[0] = room;
            ea[1] = {addr[31:12] + 20'd1, 12'h000}; eb[1] = beats - room;
            tag = "R2";
        end else begin
            exp_n = 1;
            ea[0] = addr; eb[0] = beats;
            tag = (burst == 0) ? "R5" : "R6";
        end

        @(negedge clk);
        chk(req_ready && !ax_valid, "R8", "ready before request", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = 8'(beats - 1);
        req_size  = 3'(size);
        req_burst = 2'(burst);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ax_valid == (exp_n > 0), "R9", "valid after request", longint'(ax_valid), longint'(exp_n > 0));
        chk(req_reject == (exp_n == 0), "R4", "reject pulse", longint'(req_reject), longint'(exp_n == 0));
        chk(req_ready == (exp_n == 0), "R8", "ready while busy", longint'(req_ready), longint'(exp_n == 0));
        if (exp_n == 0) begin
            @(negedge clk);
            chk(!req_reject && !ax_valid, "R4", "reject lasts one cycle", longint'(req_reject), 0);
            return;
        end

        k = 0;
        got_sum = 0;
        stalled = 1'b0;
        s_addr = '0;
        s_len = '0;
        while (k < exp_n) begin
            chk(ax_valid, "R9", "valid until last burst", longint'(ax_valid), 1);
            if (stalled) begin
                chk(ax_addr == s_addr && ax_len == s_len, "R10", "hold during stall",
                    longint'(ax_addr), longint'(s_addr));
            end
            ax_ready = (($urandom % 4) != 0);
            if (ax_valid && ax_ready) begin
                chk(ax_addr == ea[k], tag, "burst address", longint'(ax_addr), longint'(ea[k]));
                chk(int'(ax_len) == eb[k] - 1, "R7", "burst length", longint'(ax_len), longint'(eb[k] - 1));
                chk(int'(ax_size) == size, "R7", "burst size", longint'(ax_size), longint'(size));
                chk(int'(ax_burst) == burst, "R3", "burst code", longint'(ax_burst), longint'(burst));
                got_sum += int'(ax_len) + 1;
                k++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
                s_addr = ax_addr;
                s_len = ax_len;
            end
            @(posedge clk);
            @(negedge clk);
        end
        ax_ready = 1'b0;
        chk(got_sum == beats, "R1", "beat total", longint'(got_sum), longint'(beats));
        chk(!ax_valid && req_ready, "R8", "idle after last burst", longint'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!ax_valid && !req_reject && req_ready, "R11", "state in reset", longint'(ax_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ax_valid && !req_reject && req_ready, "R11", "state after reset", longint'(req_ready), 1);

        run_req(32'h0000_0F00, 64, 2, 1);   // R6 ends exactly on boundary
        run_req(32'h0000_0FF0, 16, 2, 1);   // R1 split 4 + 12
        run_req(32'h0000_1FFE, 4, 2, 1);    // R2 unaligned start, 1 + 3
        run_req(32'h0000_0FFC, 16, 2, 0);   // R5 fixed never split
        run_req(32'h0000_0FF0, 8, 2, 2);    // R4 wrapping refused
        run_req(32'h0000_0FF0, 8, 2, 3);    // R4 reserved refused
        run_req(32'h0000_3000, 256, 4, 1);  // R6 full page single
        run_req(32'h0000_5FFF, 2, 0, 1);    // R1 byte beats 1 + 1
        run_req(32'hFFFF_FFF0, 8, 2, 1);    // R2 second burst wraps to zero
        run_req(32'h0000_7F80, 1, 7, 1);    // R6 one wide beat

        for (int i = 0; i < 400; i++) begin
            int          sz;
            int          maxb;
            int          nb;
            int          bt;
            int          sel;
            logic [31:0] a;
            sz   = int'($urandom % 8);
            maxb = ((PAGE >> sz) < 256) ? (PAGE >> sz) : 256;
            nb   = 1 + int'($urandom % maxb);
            sel  = int'($urandom % 10);
            bt   = (sel < 7) ? 1 : (sel < 9) ? 0 : 2 + int'($urandom % 2);
            a    = $urandom;
            if (($urandom % 2) == 0) a[11:0] = 12'(PAGE - 1 - int'($urandom % 600));
            if (bt == 0 || ($urandom % 2) == 0) a = a & ~((32'd1 << sz) - 32'd1);
            run_req(a, nb, sz, bt);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule